// File: doc/BRIEF.md
# Serial Transceiver with Fractional FIFO Interrupts

This block is an asynchronous serial transmitter and receiver. Each direction has a 16-entry FIFO. Software reaches the block through a small register bus with two addresses:

- **Data address.** A write queues a byte for sending. A read returns the oldest received entry and removes it from the FIFO.
- **Configuration address.** A write sets the parity mode, the break command and the two interrupt thresholds.

Bit timing comes from a 16x oversampling tick, supplied from outside as a one-cycle pulse. One bit lasts 16 ticks.

Each FIFO drives its own interrupt. The receiver does the following:

- It rejects false start bits.
- It samples every bit in its middle.
- It stores parity, framing and break flags alongside each byte.
- It detects a line held low through the whole frame, including the stop-bit position, and records it as a break.

The transmitter can also hold its line low on command, which produces a break on the line.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset the following hold: `tx_o` is 1, `tx_irq_o` is 1, `rx_irq_o` is 0, and `rdata_o` is 0.
- R2: A transmitted frame is made of:
  - a low start bit;
  - 8 data bits, least significant bit first;
  - a parity bit, only when parity is enabled;
  - one high stop bit.

  Each bit lasts 16 ticks.
- R3: The parity mode is configuration bits [1:0]: 0 and 3 select no parity, 1 selects even parity, and 2 selects odd parity. With even parity, the XOR of the data bits and the parity bit is 0. With odd parity it is 1.
- R4: A received frame is pushed into the RX FIFO. A read with `addr_i`=0 shows the head entry on `rdata_o` and pops it at the clock edge. The `rdata_o` fields are:
  - [11]: valid;
  - [10]: break;
  - [9]: framing error;
  - [8]: parity error;
  - [7:0]: data.
- R5: Bit [8] (parity error) is set when parity is enabled and the received parity bit does not match the configured mode.
- R6: Bit [9] (framing error) is set when the stop bit is sampled low. After a low stop bit, the receiver waits for the line to return high before it looks for a new start bit.
- R7: While configuration bit [2] is 1, `tx_o` is held low. No new frame starts during that time. A byte queued during the break is sent after the break is released.
- R8: When RX stays low through the data, parity and stop positions, exactly one entry is stored. That entry has data 0 and bits [10] and [9] set.
- R9: A start edge is dropped, and nothing is stored, when RX is high again at sample 8 of the start bit. The next valid frame is still received.
- R10: `tx_irq_o` is 1 when the TX FIFO level is at or below the TX threshold.
- R11: `rx_irq_o` is 1 when the RX FIFO level is at or above the RX threshold.
- R12: The TX threshold selector is configuration bits [5:3]. The RX threshold selector is bits [8:6]. The selector values map to levels as follows: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 12, 4 gives 14, and 5 to 7 give 8.
- R13: A push into a full FIFO is dropped. A read of an empty RX FIFO returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 16x oversampling tick, one-cycle pulse |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; pops the RX FIFO at address 0 |
| addr_i | input | 1 | 0 = data, 1 = configuration |
| wdata_i | input | 9 | Write data; [7:0] carries a byte at address 0 |
| rdata_o | output | 12 | RX head entry when `addr_i`=0 and the FIFO is not empty, otherwise 0 |
| rx_i | input | 1 | Serial input, idle high |
| tx_o | output | 1 | Serial output, idle high |
| tx_irq_o | output | 1 | TX FIFO level at or below its threshold |
| rx_irq_o | output | 1 | RX FIFO level at or above its threshold |

## Verification
The bench targets the following corner cases; a faulty design would fail them as described:

- **Equality edges of both thresholds.**
  - TX: two queued bytes against a level of 2 must keep `tx_irq_o` high. A design that used a strict comparison would drop it there.
  - RX: 13 and 14 entries against a level of 14 show whether the RX comparison is off by one.
- **Break.** A held-low line must give one flagged entry and no phantom second frame. A receiver that re-armed on a low line would store a second, garbage entry.
- **False start.** A short glitch must store nothing, and the frame after it must still be received.
- **Full FIFO.** With 17 frames arriving into 16 slots, the 17th must be dropped. A design that overwrote the head instead would return a wrong first byte on read-back.

// File: rtl/uart_fifo_irq_pkg.sv
package uart_fifo_irq_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } par_e;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [DATA_W-1:0] data;
  } rx_ent_t;

  // fraction of depth chosen by a 3-bit selector; unused codes fall back to 1/2
  function automatic int unsigned thr_level(input logic [2:0] sel, input int unsigned depth);
    case (sel)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (depth * 3) / 4;
      3'd4:    return (depth * 7) / 8;
      default: return depth / 2;
    endcase
  endfunction
endpackage

// File: rtl/uart_fifo_q.sv
module uart_fifo_q #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [LW-1:0] level_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt_q < LW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);
  assign dout_o  = mem[rp_q];
  assign level_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_txser.sv
module uart_txser
  import uart_fifo_irq_pkg::*;
#(
  parameter int DW = 8,
  localparam int FW = DW + 3,
  localparam int BW = $clog2(FW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [1:0]    par_i,
  input  logic          hold_i,
  input  logic          avail_i,
  input  logic [DW-1:0] data_i,
  output logic          pop_o,
  output logic          line_o
);
  logic          busy_q;
  logic [FW-1:0] sh_q;
  logic [3:0]    tc_q;
  logic [BW-1:0] bi_q, nb_q;
  logic          par_on, pbit;

  assign par_on = (par_i == PAR_EVEN) || (par_i == PAR_ODD);
  assign pbit   = (^data_i) ^ (par_i == PAR_ODD);
  assign pop_o  = !busy_q && avail_i && !hold_i;
  assign line_o = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      tc_q   <= '0;
      bi_q   <= '0;
      nb_q   <= '0;
    end else if (pop_o) begin
      busy_q <= 1'b1;
      sh_q   <= {1'b1, par_on ? pbit : 1'b1, data_i, 1'b0};
      nb_q   <= par_on ? BW'(DW + 3) : BW'(DW + 2);
      tc_q   <= '0;
      bi_q   <= '0;
    end else if (busy_q && tick_i) begin
      if (tc_q == 4'd15) begin
        tc_q <= '0;
        sh_q <= {1'b1, sh_q[FW-1:1]};
        if (bi_q == nb_q - 1'b1) busy_q <= 1'b0;
        else                     bi_q   <= bi_q + 1'b1;
      end else begin
        tc_q <= tc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rxdes.sv
module uart_rxdes
  import uart_fifo_irq_pkg::*;
#(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] par_i,
  output logic       push_o,
  output rx_ent_t    ent_o
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAIT} st_e;

  st_e           st_q;
  logic [3:0]    tc_q;
  logic [IW-1:0] bi_q;
  logic [DW-1:0] sh_q;
  logic          pb_q, par_on, mid, exp_p;

  assign par_on = (par_i == PAR_EVEN) || (par_i == PAR_ODD);
  assign mid    = tick_i && (tc_q == 4'd15);
  assign exp_p  = (^sh_q) ^ (par_i == PAR_ODD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      tc_q   <= '0;
      bi_q   <= '0;
      sh_q   <= '0;
      pb_q   <= 1'b0;
      push_o <= 1'b0;
      ent_o  <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick_i && st_q != S_IDLE && st_q != S_WAIT) tc_q <= tc_q + 1'b1;
      unique case (st_q)
        S_IDLE: if (tick_i && !rx_i) begin
          st_q <= S_START;
          tc_q <= '0;
        end
        S_START: if (tick_i && tc_q == 4'd7) begin
          tc_q <= '0;
          bi_q <= '0;
          st_q <= rx_i ? S_IDLE : S_DATA;  // high at mid start: false edge
        end
        S_DATA: if (mid) begin
          sh_q <= {rx_i, sh_q[DW-1:1]};
          bi_q <= bi_q + 1'b1;
          if (bi_q == IW'(DW - 1)) st_q <= par_on ? S_PAR : S_STOP;
        end
        S_PAR: if (mid) begin
          pb_q <= rx_i;
          st_q <= S_STOP;
        end
        S_STOP: if (mid) begin
          push_o     <= 1'b1;
          ent_o.data <= sh_q;
          ent_o.pe   <= par_on && (pb_q != exp_p);
          ent_o.fe   <= !rx_i;
          ent_o.brk  <= !rx_i && (sh_q == '0) && !(par_on && pb_q);
          st_q       <= rx_i ? S_IDLE : S_WAIT;
        end
        S_WAIT: if (rx_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH) + 1,
  localparam int EW   = $bits(rx_ent_t),
  localparam int RDW  = EW + 1,
  localparam int CW   = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           we_i,
  input  logic           re_i,
  input  logic           addr_i,
  input  logic [CW-1:0]  wdata_i,
  output logic [RDW-1:0] rdata_o,
  input  logic           rx_i,
  output logic           tx_o,
  output logic           tx_irq_o,
  output logic           rx_irq_o
);
  logic [CW-1:0]     cfg_q;
  logic [1:0]        rx_sync_q;
  logic [1:0]        cfg_par;
  logic              cfg_brk;
  logic [2:0]        tx_sel, rx_sel;
  logic [LW-1:0]     tx_lvl, rx_lvl, tx_thr, rx_thr;
  logic [DATA_W-1:0] tx_head;
  logic              tx_push, tx_pop, tx_line;
  logic              rx_push, rx_pop;
  rx_ent_t           rx_ent, rx_head;

  assign cfg_par = cfg_q[1:0];
  assign cfg_brk = cfg_q[2];
  assign tx_sel  = cfg_q[5:3];
  assign rx_sel  = cfg_q[8:6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      rx_sync_q <= 2'b11;
    end else begin
      rx_sync_q <= {rx_sync_q[0], rx_i};
      if (we_i && addr_i) cfg_q <= wdata_i;
    end
  end

  assign tx_push = we_i && !addr_i;
  assign rx_pop  = re_i && !addr_i;

  uart_fifo_q #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni, .push_i(tx_push), .din_i(wdata_i[DATA_W-1:0]),
    .pop_i(tx_pop), .dout_o(tx_head), .level_o(tx_lvl)
  );

  uart_fifo_q #(.W(EW), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni, .push_i(rx_push), .din_i(rx_ent),
    .pop_i(rx_pop), .dout_o(rx_head), .level_o(rx_lvl)
  );

  uart_txser #(.DW(DATA_W)) u_tx (
    .clk_i, .rst_ni, .tick_i, .par_i(cfg_par), .hold_i(cfg_brk),
    .avail_i(tx_lvl != '0), .data_i(tx_head), .pop_o(tx_pop), .line_o(tx_line)
  );

  uart_rxdes #(.DW(DATA_W)) u_rx (
    .clk_i, .rst_ni, .tick_i, .rx_i(rx_sync_q[1]), .par_i(cfg_par),
    .push_o(rx_push), .ent_o(rx_ent)
  );

  assign tx_thr   = LW'(thr_level(tx_sel, DEPTH));
  assign rx_thr   = LW'(thr_level(rx_sel, DEPTH));
  assign tx_irq_o = (tx_lvl <= tx_thr);
  assign rx_irq_o = (rx_lvl >= rx_thr);
  assign tx_o     = tx_line && !cfg_brk;
  assign rdata_o  = (!addr_i && rx_lvl != '0) ? {1'b1, rx_head} : '0;
endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          brk_i,
  input logic          tx_line_i,
  input logic [LW-1:0] tx_lvl_i,
  input logic [LW-1:0] rx_lvl_i,
  input logic          tx_irq_i,
  input logic          rx_irq_i,
  input logic          rx_push_i,
  input logic          rx_pop_i
);
  // R7
  a_r7_break_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !tx_line_i);

  // R13
  a_r13_levels_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_lvl_i <= LW'(DEPTH)) && (rx_lvl_i <= LW'(DEPTH)));

  a_r13_full_drops_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && !rx_pop_i && rx_lvl_i == LW'(DEPTH)) |=> rx_lvl_i == LW'(DEPTH));

  // R4
  a_r4_push_grows_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && !rx_pop_i && rx_lvl_i < LW'(DEPTH)) |=> rx_lvl_i == $past(rx_lvl_i) + 1'b1);

  // R11
  a_r11_rx_irq_quiet_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_lvl_i == '0) |-> !rx_irq_i);

  // R10
  a_r10_tx_irq_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_lvl_i == '0) |-> tx_irq_i);
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .brk_i(cfg_brk), .tx_line_i(tx_o),
  .tx_lvl_i(tx_lvl), .rx_lvl_i(rx_lvl), .tx_irq_i(tx_irq_o), .rx_irq_i(rx_irq_o),
  .rx_push_i(rx_push), .rx_pop_i(rx_pop)
);

// File: tb/sim_uart_fifo_irq.sv
`timescale 1ns/100ps
module sim_uart_fifo_irq;
  localparam int BITC = 32;  // clocks per bit: 16 ticks, one tick every 2 clocks

  logic        clk_i = 1'b0, rst_ni = 1'b0, tdiv = 1'b0;
  logic        we_i = 1'b0, re_i = 1'b0, addr_i = 1'b0, rx_i = 1'b1;
  logic [8:0]  wdata_i = '0;
  logic [11:0] rdata_o;
  logic        tx_o, tx_irq_o, rx_irq_o;

  int n_chk = 0, n_fail = 0;
  bit chk_en = 1'b0, done = 1'b0;
  logic [11:0] q[$];
  logic [2:0]  rx_sel_m = 3'd0;

  always #2.5 clk_i = ~clk_i;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) tdiv <= 1'b0; else tdiv <= ~tdiv;

  uart_fifo_irq u0 (
    .clk_i, .rst_ni, .tick_i(tdiv), .we_i, .re_i, .addr_i, .wdata_i,
    .rdata_o, .rx_i, .tx_o, .tx_irq_o, .rx_irq_o
  );

  function automatic int thr_of(input logic [2:0] s);
    case (s) 3'd0: return 2; 3'd1: return 4; 3'd2: return 8;
      3'd3: return 12; 3'd4: return 14; default: return 8; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // every-clock reference comparison of the RX interrupt
  always @(negedge clk_i)
    if (chk_en) chk(rx_irq_o == (q.size() >= thr_of(rx_sel_m)), "R11 rx_irq per clock",
                    rx_irq_o, q.size() >= thr_of(rx_sel_m));

  task automatic wr(input logic a, input logic [8:0] d);
    @(posedge clk_i); #1 we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1 we_i = 1'b0; addr_i = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] par, input logic brk, input logic [2:0] txs,
                     input logic [2:0] rxs);
    wr(1'b1, {rxs, txs, brk, par});
    rx_sel_m = rxs;
  endtask

  task automatic rd_chk(input string req);
    logic [11:0] e;
    e = (q.size() != 0) ? q[0] : 12'h000;
    @(posedge clk_i); #1 re_i = 1'b1; addr_i = 1'b0;
    @(negedge clk_i);
    chk(rdata_o == e, req, rdata_o, e);
    @(posedge clk_i); #1 re_i = 1'b0;
    if (q.size() != 0) void'(q.pop_front());
  endtask

  task automatic model_push(input logic [11:0] e);
    if (q.size() < 16) q.push_back(e);
  endtask

  task automatic rx_send(input logic [7:0] d, input bit par_on, input bit odd,
                         input bit bad_par, input bit stop_v);
    logic pb;
    chk_en = 1'b0;
    pb = (^d) ^ odd ^ bad_par;
    rx_i = 1'b0; repeat (BITC) @(posedge clk_i);
    for (int i = 0; i < 8; i++) begin rx_i = d[i]; repeat (BITC) @(posedge clk_i); end
    if (par_on) begin rx_i = pb; repeat (BITC) @(posedge clk_i); end
    rx_i = stop_v; repeat (BITC) @(posedge clk_i);
    rx_i = 1'b1; repeat (2 * BITC) @(posedge clk_i);
    model_push({1'b1, !stop_v && d == 8'h00 && !(par_on && pb), !stop_v,
                par_on && bad_par, d});
    #1 chk_en = 1'b1;
  endtask

  task automatic tx_decode(input bit par_on, output logic [7:0] d, output logic p,
                           output logic st, output logic sp);
    int t = 0;
    p = 1'b0;
    while (tx_o !== 1'b0 && t < 4000) begin @(posedge clk_i); #1 t++; end
    repeat (BITC / 2) @(posedge clk_i); #1 st = tx_o;
    for (int i = 0; i < 8; i++) begin repeat (BITC) @(posedge clk_i); #1 d[i] = tx_o; end
    if (par_on) begin repeat (BITC) @(posedge clk_i); #1 p = tx_o; end
    repeat (BITC) @(posedge clk_i); #1 sp = tx_o;
  endtask

  task automatic tx_frame(input logic [7:0] exp, input bit par_on, input logic exp_p,
                          input string req);
    logic [7:0] d; logic p, st, sp;
    tx_decode(par_on, d, p, st, sp);
    chk(st == 1'b0, {req, " start bit"}, st, 0);
    chk(d == exp, {req, " data"}, d, exp);
    if (par_on) chk(p == exp_p, {req, " parity bit"}, p, exp_p);
    chk(sp == 1'b1, {req, " stop bit"}, sp, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    repeat (4) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(tx_o == 1'b1, "R1 tx_o idle", tx_o, 1);
    chk(tx_irq_o == 1'b1, "R1 tx_irq", tx_irq_o, 1);
    chk(rx_irq_o == 1'b0, "R1 rx_irq", rx_irq_o, 0);
    chk(rdata_o == 12'h000, "R1 rdata", rdata_o, 0);
    chk_en = 1'b1;

    // R2 plain frame, R3 even and odd parity bits
    wr(1'b0, 9'h0A5);
    tx_frame(8'hA5, 1'b0, 1'b0, "R2");
    cfg(2'd1, 1'b0, 3'd0, 3'd0);
    wr(1'b0, 9'h007);
    tx_frame(8'h07, 1'b1, 1'b1, "R3 even");
    cfg(2'd2, 1'b0, 3'd0, 3'd0);
    wr(1'b0, 9'h007);
    tx_frame(8'h07, 1'b1, 1'b0, "R3 odd");
    repeat (2 * BITC) @(posedge clk_i);

    // R7 break with R10 threshold edges (TX threshold 2)
    cfg(2'd0, 1'b1, 3'd0, 3'd0);
    repeat (50) @(posedge clk_i); #1;
    chk(tx_o == 1'b0, "R7 break low", tx_o, 0);
    wr(1'b0, 9'h011); wr(1'b0, 9'h022);
    #1 chk(tx_irq_o == 1'b1, "R10 level 2 at threshold 2", tx_irq_o, 1);
    wr(1'b0, 9'h033);
    #1 chk(tx_irq_o == 1'b0, "R10 level 3 above threshold", tx_irq_o, 0);
    repeat (400) @(posedge clk_i); #1;
    chk(tx_o == 1'b0, "R7 no frame during break", tx_o, 0);
    cfg(2'd0, 1'b0, 3'd0, 3'd0);
    tx_frame(8'h11, 1'b0, 1'b0, "R7 queued byte after break");
    chk(tx_irq_o == 1'b1, "R10 drained to 2", tx_irq_o, 1);
    tx_frame(8'h22, 1'b0, 1'b0, "R7 second");
    tx_frame(8'h33, 1'b0, 1'b0, "R7 third");

    // R4 receive, R5 parity, R6 framing, R8 break
    rx_send(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1);
    cfg(2'd1, 1'b0, 3'd0, 3'd0);
    rx_send(8'h01, 1'b1, 1'b0, 1'b1, 1'b1);
    rx_send(8'h81, 1'b1, 1'b0, 1'b0, 1'b1);
    cfg(2'd0, 1'b0, 3'd0, 3'd0);
    rx_send(8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_en = 1'b0;
    rx_i = 1'b0; repeat (12 * BITC) @(posedge clk_i);
    rx_i = 1'b1; repeat (2 * BITC) @(posedge clk_i);
    model_push(12'hE00);
    #1 chk_en = 1'b1;
    rd_chk("R4 plain byte");
    rd_chk("R5 parity error flagged");
    rd_chk("R5 good even parity");
    rd_chk("R6 framing error");
    rd_chk("R8 break entry");
    rd_chk("R8 single break entry, then R13 empty read");

    // R9 false start then a good frame
    chk_en = 1'b0;
    rx_i = 1'b0; repeat (8) @(posedge clk_i);
    rx_i = 1'b1; repeat (2 * BITC) @(posedge clk_i);
    #1 chk_en = 1'b1;
    rd_chk("R9 glitch stored nothing");
    rx_send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1);
    rd_chk("R9 frame after glitch");

    // R11 and R12 with threshold 14, then R13 overflow with 17 frames
    cfg(2'd0, 1'b0, 3'd0, 3'd4);
    for (int i = 0; i < 17; i++) begin
      rx_send(8'(i + 8'h40), 1'b0, 1'b0, 1'b0, 1'b1);
      if (i == 12) chk(rx_irq_o == 1'b0, "R11 13 below 14", rx_irq_o, 0);
      if (i == 13) chk(rx_irq_o == 1'b1, "R11 14 at 14", rx_irq_o, 1);
    end
    cfg(2'd0, 1'b0, 3'd0, 3'd3);
    chk(rx_irq_o == 1'b1, "R12 selector 3 gives 12", rx_irq_o, 1);
    cfg(2'd0, 1'b0, 3'd0, 3'd6);
    for (int i = 0; i < 17; i++) rd_chk("R13 overflow read-back");

    repeat (10) @(posedge clk_i);
    report();
  end
endmodule